// File: doc/BRIEF.md
# Stack Limit Zone Checker

This block checks every stack write against a lower bound on the stack and gives one of three results: safe, yellow zone or red zone. A yellow-zone write may complete, but it sets a sticky pending flag so that the processor takes a trap once the current operation ends. A red-zone write must be aborted, and the block signals this with a one-cycle abort pulse so that the trap happens at once. The yellow flag stays set until the processor reports that it has taken the trap.

In kernel mode the bound is a programmable limit register. Software can read and write it through a word-wide register port, but only its upper byte is stored. The red zone covers every address from zero up to and including limit+0x00DF. The yellow zone is the 16 words from limit+0x00E0 to limit+0x00FF. In user mode the block ignores the register and uses a fixed floor at 0x0100, below which a write aborts at once. A build option removes the register and fixes the kernel limit at zero. Trap sequencing and memory lie outside this block.

Top module: `stack_zone_guard`

## Requirements
- R1: After a synchronous reset, red_abort and yellow_pend are 0, reg_rdata is 0 and the limit register holds 0.
- R2: The limit register sits at reg_addr 0xFFFC. A write there stores bits 15:8 of reg_wdata. A read there returns {stored byte, 8'h00} on reg_rdata in the cycle after reg_rd. A read of any other address returns 0, and a write to any other address leaves the register unchanged.
- R3: In kernel mode (acc_kernel=1), a qualified stack write at an address from 0 up to and including limit+0x00DF (unsigned) makes red_abort high for exactly the next cycle.
- R4: In kernel mode, a qualified write from limit+0x00E0 through limit+0x00FF sets yellow_pend in the next cycle and does not raise red_abort. Zone bounds are computed without wraparound.
- R5: In kernel mode, a qualified write at or above limit+0x0100 raises neither output.
- R6: In user mode (acc_kernel=0), the limit register is ignored. A write below 0x0100 raises red_abort in the next cycle, a write at or above 0x0100 raises nothing, and user writes never set yellow_pend.
- R7: yellow_pend stays high until a cycle with trap_taken=1 and no new yellow write. It is low from the next cycle. A yellow write in the same cycle as trap_taken keeps it high.
- R8: When acc_valid is 0, the address, mode and limit produce no red_abort and no change to yellow_pend.
- R9: With HAS_LIMIT_REG=0, the kernel limit is fixed at 0, writes to 0xFFFC have no effect and reads of it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_rd | input | 1 | Register port read strobe |
| reg_addr | input | 16 | Register port address |
| reg_wdata | input | 16 | Register port write data |
| reg_rdata | output | 16 | Registered read data, 0 when there was no matching read |
| acc_valid | input | 1 | Qualifies acc_addr as a stack write |
| acc_addr | input | 16 | Stack write address |
| acc_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| trap_taken | input | 1 | Clears the pending yellow flag |
| red_abort | output | 1 | One-cycle pulse: abort and trap at once |
| yellow_pend | output | 1 | Sticky flag: trap after the operation completes |

## Verification
The bench builds two instances from the same stimulus. One uses the default HAS_LIMIT_REG=1, which lets it move the zones across the whole address space, including the top limit byte, where limit+0x00FF reaches 0xFFFF. The other uses HAS_LIMIT_REG=0. Comparing the two after a register write shows that the fixed variant ignores the register, and that its kernel zones match a fixed 0x0100 boundary. Boundary addresses on each side of every zone edge are checked in both modes.

// File: rtl/szg_pkg.sv
package szg_pkg;
  typedef enum logic [1:0] {
    ZONE_SAFE   = 2'd0,
    ZONE_YELLOW = 2'd1,
    ZONE_RED    = 2'd2
  } zone_e;
endpackage

// File: rtl/szg_limit_reg.sv
module szg_limit_reg #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] REG_ADDR = 16'hFFFC,
  parameter bit          HAS_REG  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] rdata,
  output logic [ADDR_W-1:0] limit
);
  localparam int LO_W = 8;
  localparam int HI_W = ADDR_W - LO_W;

  logic [HI_W-1:0] limit_hi;
  logic            sel;

  assign sel = (addr == REG_ADDR[ADDR_W-1:0]);

  generate
    if (HAS_REG) begin : g_reg
      logic [HI_W-1:0] hi_q;
      logic            unused_lo;
      assign unused_lo = ^wdata[LO_W-1:0];
      always_ff @(posedge clk) begin
        if (rst)              hi_q <= '0;
        else if (wr_en && sel) hi_q <= wdata[ADDR_W-1:LO_W];
      end
      assign limit_hi = hi_q;
    end else begin : g_fixed
      logic unused_in;
      assign unused_in = ^{wdata, wr_en};
      assign limit_hi  = '0;
    end
  endgenerate

  assign limit = {limit_hi, {LO_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst)               rdata <= '0;
    else if (rd_en && sel) rdata <= limit;
    else                   rdata <= '0;
  end
endmodule

// File: rtl/szg_zone_classify.sv
module szg_zone_classify
  import szg_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int RED_TOP    = 'h00DF,
  parameter int YEL_TOP    = 'h00FF,
  parameter int USER_FLOOR = 'h0100
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              kernel,
  input  logic [ADDR_W-1:0] limit,
  output zone_e             zone
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] addr_x, red_bound, yel_bound;

  assign addr_x    = {1'b0, addr};
  assign red_bound = {1'b0, limit} + EW'(RED_TOP);
  assign yel_bound = {1'b0, limit} + EW'(YEL_TOP);

  always_comb begin
    zone = ZONE_SAFE;
    if (kernel) begin
      if (addr_x <= red_bound)      zone = ZONE_RED;
      else if (addr_x <= yel_bound) zone = ZONE_YELLOW;
    end else begin
      if (addr_x < EW'(USER_FLOOR)) zone = ZONE_RED;
    end
  end
endmodule

// File: rtl/stack_zone_guard.sv
module stack_zone_guard
  import szg_pkg::*;
#(
  parameter int          ADDR_W        = 16,
  parameter logic [15:0] LIMIT_ADDR    = 16'hFFFC,
  parameter bit          HAS_LIMIT_REG = 1'b1,
  parameter int          RED_TOP       = 'h00DF,
  parameter int          YEL_TOP       = 'h00FF,
  parameter int          USER_FLOOR    = 'h0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_kernel,
  input  logic              trap_taken,
  output logic              red_abort,
  output logic              yellow_pend
);
  logic [ADDR_W-1:0] limit;
  zone_e             zone;
  logic              hit_red, hit_yel;

  szg_limit_reg #(
    .ADDR_W(ADDR_W), .REG_ADDR(LIMIT_ADDR), .HAS_REG(HAS_LIMIT_REG)
  ) u_limit (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata), .limit(limit)
  );

  szg_zone_classify #(
    .ADDR_W(ADDR_W), .RED_TOP(RED_TOP), .YEL_TOP(YEL_TOP),
    .USER_FLOOR(USER_FLOOR)
  ) u_class (
    .addr(acc_addr), .kernel(acc_kernel), .limit(limit), .zone(zone)
  );

  assign hit_red = acc_valid && (zone == ZONE_RED);
  assign hit_yel = acc_valid && (zone == ZONE_YELLOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      red_abort   <= 1'b0;
      yellow_pend <= 1'b0;
    end else begin
      red_abort <= hit_red;
      if (hit_yel)         yellow_pend <= 1'b1;
      else if (trap_taken) yellow_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/szg_checker.sv
module szg_checker #(
  parameter int ADDR_W  = 16,
  parameter bit HAS_REG = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_kernel,
  input logic              trap_taken,
  input logic              red_abort,
  input logic              yellow_pend,
  input logic [ADDR_W-1:0] reg_rdata
);
  // R8
  red_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
    red_abort |-> $past(acc_valid));

  // R7
  yellow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (yellow_pend && !trap_taken) |=> yellow_pend);

  // R4
  yellow_no_red_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(yellow_pend) |-> !red_abort);

  // R6
  yellow_kernel_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(yellow_pend) |-> $past(acc_kernel) && $past(acc_valid));

  // R2
  rdata_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[7:0] == '0) && (HAS_REG || reg_rdata == '0));
endmodule

bind stack_zone_guard szg_checker #(
  .ADDR_W(ADDR_W), .HAS_REG(HAS_LIMIT_REG)
) u_szg_checker (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kernel(acc_kernel),
  .trap_taken(trap_taken), .red_abort(red_abort),
  .yellow_pend(yellow_pend), .reg_rdata(reg_rdata)
);

// File: tb/test_stack_zone_guard.sv
module test_stack_zone_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_addr = '0, reg_wdata = '0;
  logic        acc_valid = 1'b0, acc_kernel = 1'b0, trap_taken = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [15:0] rdata, rdata_f;
  logic        red, yel, red_f, yel_f;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  stack_zone_guard i_stack_zone_guard (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kernel(acc_kernel),
    .trap_taken(trap_taken), .red_abort(red), .yellow_pend(yel)
  );

  stack_zone_guard #(.HAS_LIMIT_REG(1'b0)) i_stack_zone_guard_fixed (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_f),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kernel(acc_kernel),
    .trap_taken(trap_taken), .red_abort(red_f), .yellow_pend(yel_f)
  );

  // {kernel, limit_hi, addr, exp_red, exp_yel}
  localparam int NV = 22;
  localparam logic [26:0] VEC [0:NV-1] = '{
    {1'b1, 8'h00, 16'h0000, 2'b10}, {1'b1, 8'h00, 16'h00DF, 2'b10},
    {1'b1, 8'h00, 16'h00E0, 2'b01}, {1'b1, 8'h00, 16'h00FF, 2'b01},
    {1'b1, 8'h00, 16'h0100, 2'b00}, {1'b1, 8'h00, 16'h0001, 2'b10},
    {1'b1, 8'h10, 16'h10DF, 2'b10}, {1'b1, 8'h10, 16'h10E0, 2'b01},
    {1'b1, 8'h10, 16'h10FF, 2'b01}, {1'b1, 8'h10, 16'h1100, 2'b00},
    {1'b1, 8'h10, 16'h0500, 2'b10}, {1'b1, 8'h10, 16'hFFFF, 2'b00},
    {1'b1, 8'hFF, 16'hFFDF, 2'b10}, {1'b1, 8'hFF, 16'hFFE0, 2'b01},
    {1'b1, 8'hFF, 16'hFFFF, 2'b01}, {1'b1, 8'hFF, 16'h0000, 2'b10},
    {1'b0, 8'h10, 16'h00FF, 2'b10}, {1'b0, 8'h10, 16'h0100, 2'b00},
    {1'b0, 8'h10, 16'h1000, 2'b00}, {1'b0, 8'h10, 16'h10E0, 2'b00},
    {1'b0, 8'h00, 16'h0000, 2'b10}, {1'b0, 8'hFF, 16'hFFE0, 2'b00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [15:0] a);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic access(input logic k, input logic [15:0] a, input logic v, input logic t);
    @(negedge clk); acc_valid = v; acc_kernel = k; acc_addr = a; trap_taken = t;
    @(negedge clk); acc_valid = 1'b0; trap_taken = 1'b0;
  endtask

  task automatic clear_trap();
    @(negedge clk); trap_taken = 1'b1;
    @(negedge clk); trap_taken = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    @(negedge clk);
    chk("R1 red", {15'd0, red}, 16'd0);
    chk("R1 yellow", {15'd0, yel}, 16'd0);
    chk("R1 rdata", rdata, 16'd0);
    rd_reg(16'hFFFC);
    chk("R1 limit", rdata, 16'h0000);

    // R3 R4 R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      wr_reg(16'hFFFC, {VEC[i][25:18], 8'h00});
      clear_trap();
      access(VEC[i][26], VEC[i][17:2], 1'b1, 1'b0);
      chk($sformatf("R3/R4/R5/R6 red v%0d", i), {15'd0, red}, {15'd0, VEC[i][1]});
      chk($sformatf("R3/R4/R5/R6 yellow v%0d", i), {15'd0, yel}, {15'd0, VEC[i][0]});
    end

    // R2 readback, low byte dropped, other addresses
    wr_reg(16'hFFFC, 16'h12AB);
    rd_reg(16'hFFFC);
    chk("R2 readback", rdata, 16'h1200);
    @(negedge clk);
    chk("R2 rdata idle", rdata, 16'h0000);
    wr_reg(16'hFFFA, 16'h7700);
    rd_reg(16'hFFFC);
    chk("R2 stray write", rdata, 16'h1200);
    rd_reg(16'hFFFE);
    chk("R2 stray read", rdata, 16'h0000);

    // R3 single-cycle pulse
    access(1'b1, 16'h0000, 1'b1, 1'b0);
    chk("R3 pulse", {15'd0, red}, 16'd1);
    @(negedge clk);
    chk("R3 pulse end", {15'd0, red}, 16'd0);

    // R8 no qualifier
    clear_trap();
    access(1'b1, 16'h0000, 1'b0, 1'b0);
    chk("R8 red", {15'd0, red}, 16'd0);
    access(1'b1, 16'h12E0, 1'b0, 1'b0);
    chk("R8 yellow", {15'd0, yel}, 16'd0);

    // R7 sticky, re-access, clear, simultaneous set/clear
    access(1'b1, 16'h12E0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 held", {15'd0, yel}, 16'd1);
    access(1'b1, 16'h12F0, 1'b1, 1'b0);
    chk("R7 re-access", {15'd0, yel}, 16'd1);
    access(1'b1, 16'h12F0, 1'b1, 1'b1);
    chk("R7 set wins", {15'd0, yel}, 16'd1);
    clear_trap();
    chk("R7 cleared", {15'd0, yel}, 16'd0);

    // R9 fixed variant
    wr_reg(16'hFFFC, 16'h5500);
    rd_reg(16'hFFFC);
    chk("R9 fixed read", rdata_f, 16'h0000);
    chk("R2 ref read", rdata, 16'h5500);
    access(1'b1, 16'h00E0, 1'b1, 1'b0);
    chk("R9 fixed yellow", {15'd0, yel_f}, 16'd1);
    chk("R9 fixed no red", {15'd0, red_f}, 16'd0);
    access(1'b1, 16'h00DF, 1'b1, 1'b0);
    chk("R9 fixed red", {15'd0, red_f}, 16'd1);
    clear_trap();
    access(1'b1, 16'h0100, 1'b1, 1'b0);
    chk("R9 fixed safe red", {15'd0, red_f}, 16'd0);
    chk("R9 fixed safe yel", {15'd0, yel_f}, 16'd0);
    chk("R3 ref red at 0100", {15'd0, red}, 16'd1);

    // R1 reset clears limit and yellow
    access(1'b1, 16'h55E0, 1'b1, 1'b0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R1 yellow after reset", {15'd0, yel}, 16'd0);
    rd_reg(16'hFFFC);
    chk("R1 limit after reset", rdata, 16'h0000);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule